// File: doc/BRIEF.md
# Signed/Unsigned Integer Divide-Modulo Unit

This block computes the quotient or the remainder of an integer division for both the 32-bit and the 64-bit arithmetic classes of a packet-filter style instruction set. It handles unsigned and signed operands. The divisor is either a second register value or the 32-bit instruction immediate. The caller presents the opcode, the 16-bit offset field, the immediate and the two 64-bit register values on a valid/ready request port. The unit then works for a fixed number of cycles and returns the 64-bit writeback value with a one-cycle valid pulse.

Input back-pressure works as follows. `in_ready` is high only while the unit is idle. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A request offered while `in_ready` is low is simply not taken and leaves no trace. The result side has no back-pressure: the consumer must capture `out_data` in the cycle where `out_valid` is high. `out_data` keeps that value until the next result arrives.

A zero divisor never traps; it produces a defined writeback value. The unit uses a restoring shift-subtract loop that produces one quotient bit per cycle. Signed operations are run on magnitudes, and the signs are applied afterwards.

Top module: `dvm_divmod_unit`

## Requirements
- R1: After reset `in_ready` is high. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the result cycle.
- R2: For a request accepted at edge k, `out_valid` is high for exactly the one cycle after edge k+33 (32-bit class) or edge k+65 (64-bit class). `in_ready` returns high in that same cycle.
- R3: A request offered while `in_ready` is low is ignored. It changes neither the result nor the timing of the operation in flight.
- R4: The opcode is decoded by field:
  - bits [7:4] = 0x9 selects remainder; 0x3 (or any other value) selects quotient.
  - bit 3 = 1 takes the divisor from `in_src`; bit 3 = 0 takes it from `in_imm`.
  - bits [2:0] = 0x7 selects the 64-bit class; any other value (normally 0x4) selects the 32-bit class.
- R5: An offset of 0, or any value other than 1, selects unsigned quotient and remainder.
- R6: An offset of 1 selects signed operation. The quotient is truncated toward zero, and the remainder takes the sign of the dividend.
- R7: In signed mode, the most negative value of the class divided by -1 gives the most negative value as quotient and 0 as remainder.
- R8: A quotient with a zero divisor writes 0.
- R9: A remainder with a zero divisor writes the dividend. In the 64-bit class this is the full `in_dst`. In the 32-bit class it is `in_dst[31:0]` with the upper 32 bits cleared.
- R10: In the 32-bit class the immediate is used as a 32-bit value. In the 64-bit class it is sign-extended to 64 bits first, then treated as unsigned or signed according to the offset.
- R11: In the 32-bit class only the low 32 bits of `in_dst` and `in_src` are used, and the result is zero-extended to 64 bits.
- R12: During reset `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_opcode | input | 8 | Operation code, class and divisor source |
| in_offset | input | 16 | Signedness select (1 = signed) |
| in_imm | input | 32 | Immediate divisor |
| in_dst | input | 64 | Dividend register value |
| in_src | input | 64 | Divisor register value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 64 | Writeback value |

## Verification
The bench builds the unit with its default data width of 64, so both the 32-bit and the 64-bit class run at their architectural sizes. At this width the sign boundaries of both classes can be reached directly: most-negative by -1, all-ones immediates that sign-extend, and non-zero upper halves that the 32-bit class must ignore. The two iteration counts of 32 and 64 let a reference model that counts cycles pin down the exact result cycle and the return of `in_ready` for each class, including requests that are hammered while the unit is busy.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  localparam logic [3:0]  OPC_QUOT   = 4'h3;
  localparam logic [3:0]  OPC_REM    = 4'h9;
  localparam logic [2:0]  CLS_WIDE   = 3'h7;
  localparam logic [2:0]  CLS_HALF   = 3'h4;
  localparam logic [15:0] OFS_SIGNED = 16'd1;

  typedef struct packed {
    logic half;      // 32-bit class
    logic want_rem;  // remainder rather than quotient
    logic neg_quo;   // quotient must be negated
    logic neg_rem;   // remainder must be negated
    logic zero_div;  // divisor is zero in the active width
  } job_ctl_t;
endpackage

// File: rtl/dvm_operand_prep.sv
module dvm_operand_prep
  import dvm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [7:0]          opcode,
  input  logic [15:0]         offset,
  input  logic [DATA_W/2-1:0] imm,
  input  logic [DATA_W-1:0]   dst_val,
  input  logic [DATA_W-1:0]   src_val,
  output job_ctl_t            ctl,
  output logic [DATA_W-1:0]   dividend_pos,
  output logic [DATA_W-1:0]   divisor_mag,
  output logic [DATA_W-1:0]   dividend_raw
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              half, signed_mode, a_neg, b_neg;
  logic [DATA_W-1:0] imm_ext, src_full, a_w, b_w, a_mag, b_mag;

  always_comb begin
    half        = (opcode[2:0] != CLS_WIDE);
    signed_mode = (offset == OFS_SIGNED);
    imm_ext     = {{HALF_W{imm[HALF_W-1]}}, imm};
    src_full    = opcode[3] ? src_val : imm_ext;
    if (half) begin
      a_w   = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
      b_w   = {{HALF_W{1'b0}}, src_full[HALF_W-1:0]};
      a_neg = signed_mode & a_w[HALF_W-1];
      b_neg = signed_mode & b_w[HALF_W-1];
    end else begin
      a_w   = dst_val;
      b_w   = src_full;
      a_neg = signed_mode & a_w[DATA_W-1];
      b_neg = signed_mode & b_w[DATA_W-1];
    end
    a_mag = a_neg ? (~a_w + ONE) : a_w;
    b_mag = b_neg ? (~b_w + ONE) : b_w;
    if (half) begin
      a_mag[DATA_W-1:HALF_W] = '0;
      b_mag[DATA_W-1:HALF_W] = '0;
    end
    // 32-bit dividends sit in the upper half so HALF_W steps consume them
    dividend_pos = half ? {a_mag[HALF_W-1:0], {HALF_W{1'b0}}} : a_mag;
    divisor_mag  = b_mag;
    dividend_raw = a_w;
    ctl.half     = half;
    ctl.want_rem = (opcode[7:4] == OPC_REM);
    ctl.neg_quo  = a_neg ^ b_neg;
    ctl.neg_rem  = a_neg;
    ctl.zero_div = (b_w == '0);
  end
endmodule

// File: rtl/dvm_shift_core.sv
module dvm_shift_core #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] quo,
  output logic [DATA_W-1:0] rem
);
  logic [DATA_W-1:0] dvs_q;
  logic [DATA_W:0]   partial, trial;
  logic              fits;

  always_comb begin
    partial = {rem, quo[DATA_W-1]};
    fits    = (partial >= {1'b0, dvs_q});
    trial   = partial - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo   <= '0;
      rem   <= '0;
      dvs_q <= '0;
    end else if (load) begin
      quo   <= dividend;
      rem   <= '0;
      dvs_q <= divisor;
    end else if (step) begin
      rem <= fits ? trial[DATA_W-1:0] : partial[DATA_W-1:0];
      quo <= {quo[DATA_W-2:0], fits};
    end
  end
endmodule

// File: rtl/dvm_result_fix.sv
module dvm_result_fix
  import dvm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  job_ctl_t          ctl,
  input  logic [DATA_W-1:0] quo,
  input  logic [DATA_W-1:0] rem,
  input  logic [DATA_W-1:0] dividend_raw,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] pick, signed_val;
  logic              flip;

  always_comb begin
    pick       = ctl.want_rem ? rem : quo;
    flip       = ctl.want_rem ? ctl.neg_rem : ctl.neg_quo;
    signed_val = flip ? (~pick + ONE) : pick;
    if (ctl.half) signed_val[DATA_W-1:HALF_W] = '0;
    if (ctl.zero_div) result = ctl.want_rem ? dividend_raw : '0;
    else              result = signed_val;
  end
endmodule

// File: rtl/dvm_divmod_unit.sv
module dvm_divmod_unit
  import dvm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_opcode,
  input  logic [15:0]         in_offset,
  input  logic [DATA_W/2-1:0] in_imm,
  input  logic [DATA_W-1:0]   in_dst,
  input  logic [DATA_W-1:0]   in_src,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ITER_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ITER_HALF = CNT_W'(HALF_W);

  job_ctl_t          ctl_new, ctl_q;
  logic [DATA_W-1:0] dvd_pos, dvs_mag, raw_new, raw_q, quo, rem, fixed;
  logic              busy, accept, step, finish;
  logic [CNT_W-1:0]  cnt;

  dvm_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .opcode(in_opcode), .offset(in_offset), .imm(in_imm),
    .dst_val(in_dst), .src_val(in_src),
    .ctl(ctl_new), .dividend_pos(dvd_pos), .divisor_mag(dvs_mag),
    .dividend_raw(raw_new)
  );

  dvm_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .dividend(dvd_pos), .divisor(dvs_mag), .quo(quo), .rem(rem)
  );

  dvm_result_fix #(.DATA_W(DATA_W)) u_fix (
    .ctl(ctl_q), .quo(quo), .rem(rem), .dividend_raw(raw_q), .result(fixed)
  );

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign step     = busy & (cnt != '0);
  assign finish   = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      ctl_q     <= '0;
      raw_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        cnt   <= ctl_new.half ? ITER_HALF : ITER_FULL;
        ctl_q <= ctl_new;
        raw_q <= raw_new;
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end else if (finish) begin
        busy      <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= fixed;
      end
    end
  end
endmodule

// File: rtl/dvm_divmod_chk.sv
module dvm_divmod_chk
  import dvm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [7:0]          in_opcode,
  input logic [DATA_W/2-1:0] in_imm,
  input logic [DATA_W-1:0]   in_src,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int AGE_W  = $clog2(DATA_W + 2) + 1;

  logic             pend_half, pend_rem, pend_zero;
  logic [AGE_W-1:0] age;
  logic [DATA_W-1:0] dvs_full;

  assign dvs_full = in_opcode[3] ? in_src : {{HALF_W{in_imm[HALF_W-1]}}, in_imm};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_half <= 1'b0;
      pend_rem  <= 1'b0;
      pend_zero <= 1'b0;
      age       <= '0;
    end else if (in_valid && in_ready) begin
      pend_half <= (in_opcode[2:0] != CLS_WIDE);
      pend_rem  <= (in_opcode[7:4] == OPC_REM);
      pend_zero <= (in_opcode[2:0] != CLS_WIDE) ? (dvs_full[HALF_W-1:0] == '0)
                                                 : (dvs_full == '0);
      age       <= '0;
    end else if (!in_ready) begin
      age <= age + 1'b1;
    end
  end

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_ready_with_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (age == (pend_half ? AGE_W'(HALF_W + 1) : AGE_W'(DATA_W + 1))));

  assert_no_result_unbidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  assert_div_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pend_zero && !pend_rem) |-> (out_data == '0));

  assert_half_zero_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pend_half) |-> (out_data[DATA_W-1:HALF_W] == '0));
endmodule

bind dvm_divmod_unit dvm_divmod_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_imm(in_imm), .in_src(in_src),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_dvm_divmod_unit.sv
module sim_dvm_divmod_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [15:0] in_offset = '0;
  logic [31:0] in_imm = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R5";

  always #4 clk = ~clk;

  dvm_divmod_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_offset(in_offset), .in_imm(in_imm),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid), .out_data(out_data)
  );

  // opcodes: {code, src-bit, class}
  localparam logic [7:0] DIV64R = 8'h3F, MOD64R = 8'h9F, DIV32R = 8'h3C, MOD32R = 8'h9C;
  localparam logic [7:0] DIV64I = 8'h37, MOD64I = 8'h97, DIV32I = 8'h34, MOD32I = 8'h94;

  function automatic logic [63:0] ref_res(input logic [7:0] op, input logic [15:0] off,
                                          input logic [31:0] imm, input logic [63:0] d,
                                          input logic [63:0] s);
    logic wide, md, sg;
    logic [63:0] a, b;
    logic [31:0] a32, b32;
    longint sa, sb;
    int sa32, sb32;
    wide = (op[2:0] == 3'd7);
    md   = (op[7:4] == 4'h9);
    sg   = (off == 16'd1);
    if (wide) begin
      a = d;
      b = op[3] ? s : {{32{imm[31]}}, imm};
      if (b == 0) return md ? a : 64'd0;
      if (sg) begin
        if (a == 64'h8000_0000_0000_0000 && b == '1) return md ? 64'd0 : a;
        sa = a; sb = b;
        return md ? 64'(sa % sb) : 64'(sa / sb);
      end
      return md ? (a % b) : (a / b);
    end else begin
      a32 = d[31:0];
      b32 = op[3] ? s[31:0] : imm;
      if (b32 == 0) return md ? {32'd0, a32} : 64'd0;
      if (sg) begin
        if (a32 == 32'h8000_0000 && b32 == '1) return md ? 64'd0 : {32'd0, a32};
        sa32 = a32; sb32 = b32;
        return md ? {32'd0, 32'(sa32 % sb32)} : {32'd0, 32'(sa32 / sb32)};
      end
      return md ? {32'd0, a32 % b32} : {32'd0, a32 / b32};
    end
  endfunction

  // cycle-level reference model
  int          m_left  = 0;
  bit          m_valid = 1'b0;
  logic [63:0] m_data  = '0;
  logic [63:0] m_pend  = '0;
  string       m_tag   = "R5";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_valid = 1'b0; m_data = '0;
    end else begin
      m_valid = 1'b0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_valid = 1'b1;
          m_data  = m_pend;
        end
      end else if (in_valid) begin
        m_pend = ref_res(in_opcode, in_offset, in_imm, in_dst, in_src);
        m_left = (in_opcode[2:0] == 3'd7) ? 65 : 33;
        m_tag  = cur_tag;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(in_ready == (m_left == 0), "R1", 64'(in_ready), 64'(m_left == 0));
      check(out_valid == m_valid, "R2", 64'(out_valid), 64'(m_valid));
      if (m_valid) check(out_data == m_data, m_tag, out_data, m_data);
    end
  end

  task automatic send(input logic [7:0] op, input logic [15:0] off, input logic [31:0] imm,
                      input logic [63:0] d, input logic [63:0] s, input string tag);
    do @(negedge clk); while (!in_ready);
    cur_tag = tag;
    in_opcode = op; in_offset = off; in_imm = imm; in_dst = d; in_src = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!in_ready);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(in_ready == 1'b1, "R12", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R12", 64'(out_valid), 64'd0);
    check(out_data == 64'd0, "R12", out_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R5 unsigned basics, both classes, both divisor sources
    send(DIV64R, 16'd0, 32'd0, 64'd100, 64'd7, "R4");
    send(MOD64R, 16'd0, 32'd0, 64'd100, 64'd7, "R4");
    send(DIV64I, 16'd0, 32'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R4");
    send(MOD32I, 16'd0, 32'd10, 64'd1234, 64'd0, "R4");
    send(DIV64R, 16'd0, 32'd0, 64'h8000_0000_0000_0000, 64'd3, "R5");
    send(DIV64R, 16'd2, 32'd0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, "R5");
    // R11 upper halves ignored in the 32-bit class
    send(DIV32R, 16'd0, 32'd0, 64'hFFFF_FFFF_0000_0064, 64'hAAAA_AAAA_0000_0007, "R11");
    send(MOD32R, 16'd1, 32'd0, 64'h1234_5678_FFFF_FFF9, 64'h0000_0001_0000_0002, "R11");
    // R6 signed truncation toward zero, remainder follows dividend
    send(DIV64R, 16'd1, 32'd0, -64'sd7, 64'd2, "R6");
    send(MOD64R, 16'd1, 32'd0, -64'sd7, 64'd2, "R6");
    send(DIV64R, 16'd1, 32'd0, 64'd7, -64'sd2, "R6");
    send(MOD64R, 16'd1, 32'd0, 64'd7, -64'sd2, "R6");
    send(DIV32R, 16'd1, 32'd0, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007, "R6");
    // R7 most negative by -1
    send(DIV64R, 16'd1, 32'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    send(MOD64R, 16'd1, 32'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    send(DIV32I, 16'd1, 32'hFFFF_FFFF, 64'h0000_0000_8000_0000, 64'd0, "R7");
    send(MOD32R, 16'd1, 32'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R7");
    // R8 divide by zero
    send(DIV64R, 16'd0, 32'd0, 64'h1234_5678_9ABC_DEF0, 64'd0, "R8");
    send(DIV32R, 16'd1, 32'd0, 64'h0000_0000_0000_0055, 64'hFFFF_FFFF_0000_0000, "R8");
    send(DIV64I, 16'd1, 32'd0, 64'd77, 64'd5, "R8");
    // R9 modulo by zero
    send(MOD64R, 16'd0, 32'd0, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, "R9");
    send(MOD64R, 16'd1, 32'd0, 64'hF000_0000_0000_0001, 64'd0, "R9");
    send(MOD32R, 16'd0, 32'd0, 64'hDEAD_BEEF_0BAD_F00D, 64'hFFFF_0000_0000_0000, "R9");
    send(MOD32I, 16'd1, 32'd0, 64'hDEAD_BEEF_8000_0003, 64'd0, "R9");
    // R10 immediate sign extension only in the 64-bit class
    send(DIV64I, 16'd0, 32'hFFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R10");
    send(DIV64I, 16'd1, 32'hFFFF_FFFE, -64'sd8, 64'd0, "R10");
    send(DIV32I, 16'd0, 32'hFFFF_FFFE, 64'h0000_0000_FFFF_FFFF, 64'd0, "R10");
    send(MOD64I, 16'd0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0005, 64'd0, "R10");
    // R3 requests offered while busy are ignored
    send(DIV64R, 16'd0, 32'd0, 64'd1000, 64'd10, "R3");
    repeat (6) begin
      in_opcode = MOD32R; in_offset = 16'd1; in_dst = 64'd5; in_src = 64'd0;
      in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    send(MOD32I, 16'd0, 32'd3, 64'd17, 64'd0, "R3");
    repeat (6) begin
      in_opcode = DIV64R; in_dst = '1; in_src = 64'd1; in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();
    // R1 back-to-back with in_valid held high across the result cycle
    cur_tag = "R1";
    in_opcode = DIV32R; in_offset = 16'd0; in_dst = 64'd99; in_src = 64'd9;
    in_valid = 1'b1;
    repeat (80) @(negedge clk);
    in_valid = 1'b0;
    drain();
    // mixed random operations
    for (int i = 0; i < 160; i++) begin
      logic [7:0]  op;
      logic [15:0] off;
      logic [63:0] d, s;
      logic [31:0] im;
      op  = {($urandom % 2) ? 4'h9 : 4'h3, 1'($urandom), ($urandom % 2) ? 3'h7 : 3'h4};
      off = 16'($urandom % 2);
      d   = {$urandom, $urandom};
      case ($urandom % 4)
        0: s = {32'd0, 24'd0, 8'($urandom)};
        1: s = {$urandom, $urandom};
        2: s = 64'(-($urandom % 16));
        default: s = {32'd0, $urandom};
      endcase
      im  = ($urandom % 3 == 0) ? 32'($urandom % 9) : $urandom;
      send(op, off, im, d, s, off == 16'd1 ? "R6" : "R5");
    end
    drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule